// File: doc/BRIEF.md
# Privilege-Gated Execution-Environment Control Registers

This block is a small coprocessor-style register file with two 32-bit registers. The first is a control register. Only its bit 0, an environment-disable flag, is stored. The second holds the base address for handler routines. Each request arrives on a `req_valid` strobe. It carries a read/write flag, a privileged/unprivileged flag and a four-field selector (opc1, CRn, CRm, opc2). The block decodes the selector and checks the access against the requester's privilege and the disable flag. In the same cycle it either returns read data or raises an undefined-access pulse.

The disable flag is held in two copies. The architectural copy changes on a permitted write and reads back on the very next access. The effective copy gates unprivileged access to the base register. It picks up the architectural value only in a cycle where `sync_event` is high. That input is pulsed by a barrier, an exception entry or an exception return. Until then, access checks keep using the older value.

Requests are single-cycle and the block is always able to take one, so the request side has no ready signal and no back-pressure. The response is combinational and qualified by `req_valid`. Writes commit at the clock edge that ends the request cycle.

Top module: `cfgreg_gate`

## Requirements
- R1: After reset, the disable flag (architectural and effective) and the base register are 0.
- R2: The control register is selected by opc1=6, CRn=0, CRm=0, opc2=0. A permitted write stores only bit 0 of the write data. A read returns that bit at position 0 with bits 31:1 as zero.
- R3: An unprivileged write to the control register raises `rsp_undef` and leaves the register unchanged.
- R4: An unprivileged read of the control register is permitted (`rsp_undef`=0) and returns its value.
- R5: A read of the control register in the cycle after a permitted write returns the newly written bit, with or without any `sync_event`.
- R6: The effective disable flag loads the architectural flag, as it stood at the start of the cycle, on each clock edge where `sync_event` is high. Otherwise it holds. A write in the same cycle as the sync pulse does not take effect until a later pulse.
- R7: The base register is selected by opc1=6, CRn=1, CRm=0, opc2=0. Privileged reads and writes are permitted. Bits 1:0 always read as zero.
- R8: An unprivileged read of the base register is permitted when the effective disable flag is 0. When that flag is 1, the read raises `rsp_undef` and returns zero data.
- R9: An unprivileged write to the base register always raises `rsp_undef` and leaves it unchanged.
- R10: A selector matching neither register raises `rsp_undef`, returns zero data and changes no state.
- R11: `rsp_undef` is driven in the same cycle as `req_valid` and is 0 whenever `req_valid` is 0. `rsp_rdata` is zero unless a permitted read is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, one cycle per access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_priv | input | 1 | 1 = privileged requester |
| req_opc1 | input | 3 | Selector field opc1 |
| req_crn | input | 4 | Selector field CRn |
| req_crm | input | 4 | Selector field CRm |
| req_opc2 | input | 3 | Selector field opc2 |
| req_wdata | input | 32 | Write data |
| sync_event | input | 1 | Barrier / exception entry / exception return pulse |
| rsp_rdata | output | 32 | Read data, same cycle as the request |
| rsp_undef | output | 1 | Undefined-access pulse, same cycle as the request |

## Verification
The bench sets the disable flag and then reads the base register unprivileged, both before and after a sync pulse. A design that gated access on the architectural copy would refuse that read too early. A design that ignored the pulse would never refuse it. A write issued together with a sync pulse must not reach the effective copy, which catches a design that forwards the new value. The bench also sends refused writes and unmatched selectors, then reads the registers back to confirm they are unchanged, and it checks that the low base bits and the upper control bits read as zero.

// File: rtl/cfgreg_pkg.sv
package cfgreg_pkg;
  localparam int OPC1_W = 3;
  localparam int CRN_W  = 4;
  localparam int CRM_W  = 4;
  localparam int OPC2_W = 3;

  typedef struct packed {
    logic [OPC1_W-1:0] opc1;
    logic [CRN_W-1:0]  crn;
    logic [CRM_W-1:0]  crm;
    logic [OPC2_W-1:0] opc2;
  } sel_t;

  localparam sel_t SEL_CTRL = '{opc1: 3'd6, crn: 4'd0, crm: 4'd0, opc2: 3'd0};
  localparam sel_t SEL_BASE = '{opc1: 3'd6, crn: 4'd1, crm: 4'd0, opc2: 3'd0};

  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_CTRL = 2'd1,
    TGT_BASE = 2'd2
  } tgt_e;
endpackage

// File: rtl/cfgreg_decode.sv
module cfgreg_decode
  import cfgreg_pkg::*;
(
  input  sel_t sel,
  output tgt_e tgt
);
  always_comb begin
    if (sel == SEL_CTRL)      tgt = TGT_CTRL;
    else if (sel == SEL_BASE) tgt = TGT_BASE;
    else                      tgt = TGT_NONE;
  end
endmodule

// File: rtl/cfgreg_access.sv
module cfgreg_access
  import cfgreg_pkg::*;
(
  input  logic valid,
  input  logic write,
  input  logic priv,
  input  tgt_e tgt,
  input  logic eff_dis,
  output logic allow,
  output logic undef
);
  always_comb begin
    unique case (tgt)
      TGT_CTRL: allow = priv | ~write;
      TGT_BASE: allow = priv | (~write & ~eff_dis);
      default:  allow = 1'b0;
    endcase
    undef = valid & ~allow;
  end
endmodule

// File: rtl/cfgreg_state.sv
module cfgreg_state #(
  parameter int DATA_W     = 32,
  parameter int BASE_ALIGN = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl,
  input  logic              wr_base,
  input  logic [DATA_W-1:0] wdata,
  input  logic              sync_event,
  output logic              arch_dis,
  output logic              eff_dis,
  output logic [DATA_W-1:0] base_val
);
  localparam int HI_W = DATA_W - BASE_ALIGN;

  logic [HI_W-1:0] base_hi;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      arch_dis <= 1'b0;
      eff_dis  <= 1'b0;
      base_hi  <= '0;
    end else begin
      if (wr_ctrl)    arch_dis <= wdata[0];
      if (sync_event) eff_dis  <= arch_dis;
      if (wr_base)    base_hi  <= wdata[DATA_W-1:BASE_ALIGN];
    end
  end

  assign base_val = {base_hi, {BASE_ALIGN{1'b0}}};
endmodule

// File: rtl/cfgreg_gate.sv
module cfgreg_gate
  import cfgreg_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int BASE_ALIGN = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_priv,
  input  logic [2:0]        req_opc1,
  input  logic [3:0]        req_crn,
  input  logic [3:0]        req_crm,
  input  logic [2:0]        req_opc2,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              sync_event,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_undef
);
  sel_t              sel;
  tgt_e              tgt;
  logic              allow;
  logic              arch_dis;
  logic              eff_dis;
  logic [DATA_W-1:0] base_val;
  logic              commit;

  assign sel = '{opc1: req_opc1, crn: req_crn, crm: req_crm, opc2: req_opc2};

  cfgreg_decode u_dec (
    .sel (sel),
    .tgt (tgt)
  );

  cfgreg_access u_acc (
    .valid   (req_valid),
    .write   (req_write),
    .priv    (req_priv),
    .tgt     (tgt),
    .eff_dis (eff_dis),
    .allow   (allow),
    .undef   (rsp_undef)
  );

  assign commit = req_valid & allow;

  cfgreg_state #(
    .DATA_W     (DATA_W),
    .BASE_ALIGN (BASE_ALIGN)
  ) u_st (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_ctrl    (commit & req_write & (tgt == TGT_CTRL)),
    .wr_base    (commit & req_write & (tgt == TGT_BASE)),
    .wdata      (req_wdata),
    .sync_event (sync_event),
    .arch_dis   (arch_dis),
    .eff_dis    (eff_dis),
    .base_val   (base_val)
  );

  always_comb begin
    rsp_rdata = '0;
    if (commit && !req_write) begin
      if (tgt == TGT_CTRL)      rsp_rdata = {{(DATA_W-1){1'b0}}, arch_dis};
      else if (tgt == TGT_BASE) rsp_rdata = base_val;
    end
  end
endmodule

// File: rtl/cfgreg_gate_chk.sv
module cfgreg_gate_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic              req_priv,
  input logic              sync_event,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              rsp_undef,
  input logic              arch_dis,
  input logic              eff_dis,
  input logic [DATA_W-1:0] base_val
);
  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> (!rsp_undef && rsp_rdata == '0));

  p_write_no_data_r11: assert property (@(posedge clk) disable iff (!rst_n)
    req_write |-> rsp_rdata == '0);

  p_upriv_wr_undef_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && !req_priv) |-> rsp_undef);

  p_refused_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && rsp_undef) |=> ($stable(arch_dis) && $stable(base_val)));

  p_undef_no_data_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_undef |-> rsp_rdata == '0);

  p_eff_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_event |=> $stable(eff_dis));

  p_eff_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sync_event |=> eff_dis == $past(arch_dis));
endmodule

bind cfgreg_gate cfgreg_gate_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_write  (req_write),
  .req_priv   (req_priv),
  .sync_event (sync_event),
  .rsp_rdata  (rsp_rdata),
  .rsp_undef  (rsp_undef),
  .arch_dis   (arch_dis),
  .eff_dis    (eff_dis),
  .base_val   (base_val)
);

// File: tb/tb_cfgreg_gate.sv
module tb_cfgreg_gate;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_priv = 1'b0;
  logic [2:0]  req_opc1 = '0, req_opc2 = '0;
  logic [3:0]  req_crn = '0, req_crm = '0;
  logic [31:0] req_wdata = '0;
  logic        sync_event = 1'b0;
  logic [31:0] rsp_rdata;
  logic        rsp_undef;

  int nchk = 0, nfail = 0;
  logic [31:0] got_d;
  logic        got_u;
  bit          done = 0;

  always #(CLK_P/2) clk = ~clk;

  cfgreg_gate dut (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic req(input bit wr, input bit pv, input int o1, input int cn,
                     input int cm, input int o2, input logic [31:0] wd, input bit sy);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_priv = pv;
    req_opc1 = 3'(o1); req_crn = 4'(cn); req_crm = 4'(cm); req_opc2 = 3'(o2);
    req_wdata = wd; sync_event = sy;
    #1;
    got_d = rsp_rdata; got_u = rsp_undef;
    @(posedge clk); #1;
    req_valid = 0; sync_event = 0;
  endtask

  task automatic sync_pulse();
    @(negedge clk); sync_event = 1;
    @(posedge clk); #1 sync_event = 0;
  endtask

  task automatic rd_ctrl(input bit pv); req(0, pv, 6, 0, 0, 0, 0, 0); endtask
  task automatic rd_base(input bit pv); req(0, pv, 6, 1, 0, 0, 0, 0); endtask
  task automatic wr_ctrl(input bit pv, input logic [31:0] d); req(1, pv, 6, 0, 0, 0, d, 0); endtask
  task automatic wr_base(input bit pv, input logic [31:0] d); req(1, pv, 6, 1, 0, 0, d, 0); endtask

  task automatic t_reset();
    rd_ctrl(1); check("R1 ctrl", got_d, 0); check("R1 undef", 32'(got_u), 0);
    rd_base(1); check("R1 base", got_d, 0);
    rd_base(0); check("R1 eff allows", 32'(got_u), 0);
  endtask

  task automatic t_ctrl_rw();
    wr_ctrl(1, 32'hFFFF_FFFF); check("R2 wr undef", 32'(got_u), 0); check("R11 wr data", got_d, 0);
    rd_ctrl(1); check("R2 read bit0", got_d, 32'h1);
    wr_ctrl(1, 32'hFFFF_FFFE); rd_ctrl(1); check("R2 clear", got_d, 32'h0);
  endtask

  task automatic t_upriv_ctrl();
    wr_ctrl(0, 32'h1); check("R3 undef", 32'(got_u), 1);
    rd_ctrl(1); check("R3 unchanged", got_d, 0);
    rd_ctrl(0); check("R4 undef", 32'(got_u), 0); check("R4 data", got_d, 0);
  endtask

  task automatic t_sync();
    wr_ctrl(1, 32'h1);
    rd_ctrl(0); check("R5 immediate", got_d, 1);
    rd_base(0); check("R6 eff still old", 32'(got_u), 0);
    sync_pulse();
    rd_base(0); check("R8 refused", 32'(got_u), 1); check("R8 zero data", got_d, 0);
    rd_base(1); check("R8 priv ok", 32'(got_u), 0);
    wr_ctrl(1, 32'h0);
    rd_base(0); check("R6 held", 32'(got_u), 1);
    sync_pulse();
    rd_base(0); check("R6 released", 32'(got_u), 0);
    req(1, 1, 6, 0, 0, 0, 32'h1, 1);
    rd_ctrl(1); check("R5 same-cycle write", got_d, 1);
    rd_base(0); check("R6 same-cycle not taken", 32'(got_u), 0);
    sync_pulse();
    rd_base(0); check("R6 next pulse", 32'(got_u), 1);
    wr_ctrl(1, 0); sync_pulse();
  endtask

  task automatic t_base();
    wr_base(1, 32'h1234_5677); rd_base(1); check("R7 low bits", got_d, 32'h1234_5674);
    wr_base(0, 32'hAAAA_0000); check("R9 undef", 32'(got_u), 1);
    rd_base(1); check("R9 unchanged", got_d, 32'h1234_5674);
    rd_base(0); check("R8 allowed data", got_d, 32'h1234_5674);
  endtask

  task automatic t_unmatched();
    req(0, 1, 5, 0, 0, 0, 0, 0); check("R10 undef opc1", 32'(got_u), 1); check("R10 data", got_d, 0);
    req(0, 1, 6, 1, 0, 1, 0, 0); check("R10 undef opc2", 32'(got_u), 1); check("R10 data2", got_d, 0);
    req(1, 1, 6, 2, 0, 0, 32'hFFFF_FFFF, 0); check("R10 wr undef", 32'(got_u), 1);
    req(1, 1, 6, 0, 1, 0, 32'h1, 0); check("R10 crm undef", 32'(got_u), 1);
    rd_ctrl(1); check("R10 ctrl kept", got_d, 0);
    rd_base(1); check("R10 base kept", got_d, 32'h1234_5674);
  endtask

  task automatic t_idle();
    @(negedge clk);
    req_valid = 0; req_write = 0; req_priv = 1;
    req_opc1 = 3'd6; req_crn = 4'd1; req_crm = 0; req_opc2 = 0;
    #1;
    check("R11 idle undef", 32'(rsp_undef), 0);
    check("R11 idle data", rsp_rdata, 0);
    req_opc1 = 3'd1; #1;
    check("R11 idle bad sel", 32'(rsp_undef), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_ctrl_rw();
    t_upriv_ctrl();
    t_sync();
    t_base();
    t_unmatched();
    t_idle();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule